// File: doc/BRIEF.md
# Three-Axis Workgroup Dispatch Sequencer

This block steps through every workgroup of one compute kernel launch. A load pulse captures, for each of the three axes X, Y and Z, the size of the grid and the size of one workgroup, both in work-items. After the load, three iterative dividers find how many workgroups each axis holds, rounding up. A short multiply sequence then forms the total workgroup count. While this arithmetic runs, a busy flag is high and dispatch is held off.

Once busy falls, the block always shows the coordinate of the next workgroup to launch, together with a flat launch index. A dispatch-accept pulse from the launcher takes that workgroup and moves to the next one, with X varying fastest. The wrap test on each axis multiplies the incremented ID by the workgroup size and compares the result with the grid size. Z does not wrap: when Z meets its test, the launch is marked complete. Compute units pulse a notification when a workgroup retires. The block counts these and flags the end of the kernel once every workgroup has been launched and retired. All sizes are assumed to be nonzero.

Top module: `wg_dispatch_seq`

## Requirements
- R1: After reset, every ID output, the flat index, the completed count and the total are zero. The busy, complete and all-done outputs are low.
- R2: A load pulse raises busy in the following cycle. It clears the three IDs, the flat index, the completed count and the complete flag.
- R3: When busy falls after a load, each per-axis count output equals the grid size divided by the workgroup size, rounded up.
- R4: When busy falls after a load, the total output equals the product of the three per-axis counts.
- R5: Each accepted dispatch adds one to the flat index and, unless X wraps, one to the X ID. The outputs show the new values in the cycle after the pulse.
- R6: X wraps when (X+1) times the X workgroup size is at least the X grid size. X then returns to 0 and Y advances. Y wraps into Z by the same rule on its own axis. Launch order is therefore X fastest, then Y, then Z.
- R7: Z is never reset. When (Z+1) times the Z workgroup size is at least the Z grid size, complete goes high. At that point X and Y read 0, Z equals the Z count, and the flat index equals the total.
- R8: A dispatch pulse has no effect on the IDs or the flat index in three cases: before any load, while busy, or while complete is high.
- R9: Each workgroup-retire pulse adds one to the completed count, whether or not the block is busy or complete. A load in the same cycle takes precedence.
- R10: all-done is high exactly when complete is high and the completed count equals the total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load pulse capturing the six sizes |
| grid_x_i | input | SIZE_W | Grid size along X, in work-items |
| grid_y_i | input | SIZE_W | Grid size along Y |
| grid_z_i | input | SIZE_W | Grid size along Z |
| wgsz_x_i | input | SIZE_W | Workgroup size along X |
| wgsz_y_i | input | SIZE_W | Workgroup size along Y |
| wgsz_z_i | input | SIZE_W | Workgroup size along Z |
| disp_i | input | 1 | Dispatch-accept pulse |
| wg_done_i | input | 1 | Workgroup-retired notification |
| busy_o | output | 1 | Count arithmetic in progress |
| wg_x_o | output | SIZE_W | Current X workgroup ID |
| wg_y_o | output | SIZE_W | Current Y workgroup ID |
| wg_z_o | output | SIZE_W | Current Z workgroup ID |
| gid_o | output | 3*SIZE_W | Flat launch index |
| cnt_x_o | output | SIZE_W | Workgroups along X |
| cnt_y_o | output | SIZE_W | Workgroups along Y |
| cnt_z_o | output | SIZE_W | Workgroups along Z |
| total_o | output | 3*SIZE_W | Total workgroups |
| completed_o | output | 3*SIZE_W | Retired workgroup count |
| complete_o | output | 1 | All workgroups launched |
| all_done_o | output | 1 | All workgroups launched and retired |

## Verification
The walk is run over grids of several shapes, each of which separates a different fault:
- Grids that divide evenly catch a wrong axis order.
- A ragged X edge catches an off-by-one in the ceiling or in the wrap test.
- A workgroup larger than its grid leaves a single workgroup.
- A Z axis that needs two steps exposes a Z that is wrongly reset.
- A long single-axis run exercises many X increments.

Every launched coordinate is compared with a nested walk done in the bench. The ignored-dispatch cases are probed before any load, during the divider busy window and after completion. Retire pulses sent ahead of dispatch show that all-done waits for complete. A near-full-width grid checks the divider at its range limit.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    localparam int NDIM = 3;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_DIV  = 3'd1,
        PH_MULA = 3'd2,
        PH_MULB = 3'd3,
        PH_RUN  = 3'd4
    } phase_e;

endpackage

// File: rtl/wgd_ceil_div.sv
// Restoring divider, one quotient bit per cycle, rounding the result up.
module wgd_ceil_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] num_i,
    input  logic [W-1:0] den_i,
    output logic         ok_o,
    output logic [W-1:0] quo_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W:0]    rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  den;
        logic [CW-1:0] cnt;
        logic          run;
        logic          ok;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        dv_d    = dv_q;
        shifted = {dv_q.rem[W-1:0], dv_q.quo[W-1]};
        trial   = shifted - {1'b0, dv_q.den};
        if (start_i) begin
            dv_d.rem = '0;
            dv_d.quo = num_i;
            dv_d.den = den_i;
            dv_d.cnt = CW'(W);
            dv_d.run = 1'b1;
            dv_d.ok  = 1'b0;
        end else if (dv_q.run) begin
            if (!trial[W]) begin
                dv_d.rem = trial;
                dv_d.quo = {dv_q.quo[W-2:0], 1'b1};
            end else begin
                dv_d.rem = shifted;
                dv_d.quo = {dv_q.quo[W-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.run = 1'b0;
                dv_d.ok  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign ok_o  = dv_q.ok;
    assign quo_o = dv_q.quo + W'(dv_q.rem != '0);

endmodule

// File: rtl/wgd_axis_step.sv
// One axis of the coordinate odometer: increment on carry-in, wrap by size test.
module wgd_axis_step #(
    parameter int W         = 16,
    parameter bit KEEP_WRAP = 1'b0
) (
    input  logic         carry_i,
    input  logic [W-1:0] id_i,
    input  logic [W-1:0] wgsz_i,
    input  logic [W-1:0] grid_i,
    output logic [W-1:0] id_o,
    output logic         wrap_o
);
    localparam int PW = 2 * W;

    logic [W-1:0]  inc;
    logic [PW-1:0] reach;

    always_comb begin
        inc    = id_i + 1'b1;
        reach  = PW'(inc) * PW'(wgsz_i);
        wrap_o = carry_i && (reach >= PW'(grid_i));
        if (!carry_i) begin
            id_o = id_i;
        end else if (wrap_o && !KEEP_WRAP) begin
            id_o = '0;
        end else begin
            id_o = inc;
        end
    end

endmodule

// File: rtl/wg_dispatch_seq.sv
module wg_dispatch_seq
    import wgd_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [SIZE_W-1:0]     grid_x_i,
    input  logic [SIZE_W-1:0]     grid_y_i,
    input  logic [SIZE_W-1:0]     grid_z_i,
    input  logic [SIZE_W-1:0]     wgsz_x_i,
    input  logic [SIZE_W-1:0]     wgsz_y_i,
    input  logic [SIZE_W-1:0]     wgsz_z_i,
    input  logic                  disp_i,
    input  logic                  wg_done_i,
    output logic                  busy_o,
    output logic [SIZE_W-1:0]     wg_x_o,
    output logic [SIZE_W-1:0]     wg_y_o,
    output logic [SIZE_W-1:0]     wg_z_o,
    output logic [3*SIZE_W-1:0]   gid_o,
    output logic [SIZE_W-1:0]     cnt_x_o,
    output logic [SIZE_W-1:0]     cnt_y_o,
    output logic [SIZE_W-1:0]     cnt_z_o,
    output logic [3*SIZE_W-1:0]   total_o,
    output logic [3*SIZE_W-1:0]   completed_o,
    output logic                  complete_o,
    output logic                  all_done_o
);
    localparam int PW = 2 * SIZE_W;
    localparam int TW = 3 * SIZE_W;

    typedef struct packed {
        phase_e                        phase;
        logic [NDIM-1:0][SIZE_W-1:0]   grid;
        logic [NDIM-1:0][SIZE_W-1:0]   wgs;
        logic [NDIM-1:0][SIZE_W-1:0]   id;
        logic [NDIM-1:0][SIZE_W-1:0]   cnt;
        logic [PW-1:0]                 prod;
        logic [TW-1:0]                 total;
        logic [TW-1:0]                 gid;
        logic [TW-1:0]                 completed;
        logic                          complete;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NDIM-1:0][SIZE_W-1:0] grid_in;
    logic [NDIM-1:0][SIZE_W-1:0] wgs_in;
    logic [NDIM-1:0]             div_ok;
    logic [NDIM-1:0][SIZE_W-1:0] div_res;
    logic [NDIM-1:0][SIZE_W-1:0] id_nx;
    logic [NDIM-1:0]             wrap;
    logic [NDIM:0]               carry;

    assign grid_in = {grid_z_i, grid_y_i, grid_x_i};
    assign wgs_in  = {wgsz_z_i, wgsz_y_i, wgsz_x_i};
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < NDIM; i++) begin : g_axis
        wgd_ceil_div #(
            .W(SIZE_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (load_i),
            .num_i   (grid_in[i]),
            .den_i   (wgs_in[i]),
            .ok_o    (div_ok[i]),
            .quo_o   (div_res[i])
        );

        wgd_axis_step #(
            .W         (SIZE_W),
            .KEEP_WRAP (i == NDIM - 1)
        ) u_step (
            .carry_i (carry[i]),
            .id_i    (seq_q.id[i]),
            .wgsz_i  (seq_q.wgs[i]),
            .grid_i  (seq_q.grid[i]),
            .id_o    (id_nx[i]),
            .wrap_o  (wrap[i])
        );

        assign carry[i+1] = wrap[i];
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_DIV: begin
                if (&div_ok) begin
                    seq_d.cnt   = div_res;
                    seq_d.phase = PH_MULA;
                end
            end
            PH_MULA: begin
                seq_d.prod  = PW'(seq_q.cnt[0]) * PW'(seq_q.cnt[1]);
                seq_d.phase = PH_MULB;
            end
            PH_MULB: begin
                seq_d.total = TW'(seq_q.prod) * TW'(seq_q.cnt[2]);
                seq_d.phase = PH_RUN;
            end
            PH_RUN: begin
                if (disp_i && !seq_q.complete) begin
                    seq_d.id       = id_nx;
                    seq_d.gid      = seq_q.gid + 1'b1;
                    seq_d.complete = carry[NDIM];
                end
            end
            default: begin
            end
        endcase

        if (wg_done_i) begin
            seq_d.completed = seq_q.completed + 1'b1;
        end

        if (load_i) begin
            seq_d.grid      = grid_in;
            seq_d.wgs       = wgs_in;
            seq_d.id        = '0;
            seq_d.gid       = '0;
            seq_d.completed = '0;
            seq_d.complete  = 1'b0;
            seq_d.phase     = PH_DIV;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.phase <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o      = (seq_q.phase == PH_DIV) || (seq_q.phase == PH_MULA) ||
                         (seq_q.phase == PH_MULB);
    assign wg_x_o      = seq_q.id[0];
    assign wg_y_o      = seq_q.id[1];
    assign wg_z_o      = seq_q.id[2];
    assign gid_o       = seq_q.gid;
    assign cnt_x_o     = seq_q.cnt[0];
    assign cnt_y_o     = seq_q.cnt[1];
    assign cnt_z_o     = seq_q.cnt[2];
    assign total_o     = seq_q.total;
    assign completed_o = seq_q.completed;
    assign complete_o  = seq_q.complete;
    assign all_done_o  = seq_q.complete && (seq_q.completed == seq_q.total);

endmodule

// File: rtl/wgd_seq_chk.sv
module wgd_seq_chk #(
    parameter int SIZE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load_i,
    input logic                disp_i,
    input logic                wg_done_i,
    input logic                busy_o,
    input logic                complete_o,
    input logic                all_done_o,
    input logic [3*SIZE_W-1:0] gid_o,
    input logic [3*SIZE_W-1:0] completed_o,
    input logic [SIZE_W-1:0]   wg_x_o,
    input logic [SIZE_W-1:0]   cnt_x_o
);
    logic loaded_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded_q <= 1'b0;
        end else if (load_i) begin
            loaded_q <= 1'b1;
        end
    end

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);                                                     // R2
    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (gid_o == '0) && (completed_o == '0) && !complete_o);        // R2
    AST_GID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        disp_i && loaded_q && !busy_o && !complete_o && !load_i
        |=> gid_o == $past(gid_o) + 1'b1);                                      // R5
    AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q && !busy_o && !complete_o |-> wg_x_o < cnt_x_o);               // R6
    AST_HOLD_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        complete_o && !load_i |=> complete_o && $stable(gid_o));                // R8
    AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !load_i |=> $stable(gid_o));                                  // R8
    AST_RETIRE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        wg_done_i && !load_i |=> completed_o == $past(completed_o) + 1'b1);     // R9
    AST_ALL_DONE_NEEDS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        all_done_o |-> complete_o);                                             // R10

endmodule

bind wg_dispatch_seq wgd_seq_chk #(
    .SIZE_W(SIZE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .disp_i      (disp_i),
    .wg_done_i   (wg_done_i),
    .busy_o      (busy_o),
    .complete_o  (complete_o),
    .all_done_o  (all_done_o),
    .gid_o       (gid_o),
    .completed_o (completed_o),
    .wg_x_o      (wg_x_o),
    .cnt_x_o     (cnt_x_o)
);

// File: tb/wg_dispatch_seq_tb.sv
module wg_dispatch_seq_tb;
    localparam int CLK_NS = 10;
    localparam int SW     = 16;
    localparam int TW     = 3 * SW;
    localparam int NVEC   = 5;

    // gx, gy, gz, wx, wy, wz, cx, cy, cz, total
    localparam int VEC [NVEC][10] = '{
        '{ 8, 4, 2, 4, 2, 1, 2, 2, 2,  8},
        '{10, 3, 1, 4, 1, 1, 3, 3, 1,  9},
        '{ 5, 5, 5, 8, 8, 8, 1, 1, 1,  1},
        '{ 7, 1, 3, 7, 1, 2, 1, 1, 2,  2},
        '{16, 1, 1, 1, 1, 1,16, 1, 1, 16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [SW-1:0] gx = '0, gy = '0, gz = '0, wx = '0, wy = '0, wz = '0;
    logic disp = 1'b0;
    logic wdone = 1'b0;
    logic busy, complete, all_done;
    logic [SW-1:0] idx, idy, idz, cx, cy, cz;
    logic [TW-1:0] gid, total, completed;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    wg_dispatch_seq #(.SIZE_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .grid_x_i(gx), .grid_y_i(gy), .grid_z_i(gz),
        .wgsz_x_i(wx), .wgsz_y_i(wy), .wgsz_z_i(wz),
        .disp_i(disp), .wg_done_i(wdone), .busy_o(busy),
        .wg_x_o(idx), .wg_y_o(idy), .wg_z_o(idz), .gid_o(gid),
        .cnt_x_o(cx), .cnt_y_o(cy), .cnt_z_o(cz), .total_o(total),
        .completed_o(completed), .complete_o(complete), .all_done_o(all_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_load(input int a, input int b, input int c,
                           input int d, input int e, input int f);
        @(negedge clk);
        gx = SW'(a); gy = SW'(b); gz = SW'(c);
        wx = SW'(d); wy = SW'(e); wz = SW'(f);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(busy == 1'b1, "R2", "busy after load", longint'(busy), 1);
        for (int n = 0; n < 200 && busy; n++) @(negedge clk);
    endtask

    task automatic pulse_disp();
        @(negedge clk); disp = 1'b1;
        @(negedge clk); disp = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); wdone = 1'b1;
        @(negedge clk); wdone = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(idx == 0 && idy == 0 && idz == 0, "R1", "ids after reset", longint'({idz, idy, idx}), 0);
        chk(gid == 0 && completed == 0 && total == 0, "R1", "counters after reset", longint'(gid), 0);
        chk(!busy && !complete && !all_done, "R1", "flags after reset",
            longint'({busy, complete, all_done}), 0);

        // R8 dispatch before any load
        pulse_disp();
        chk(gid == 0 && idx == 0, "R8", "dispatch before load", longint'(gid), 0);

        // R8 dispatch while busy
        @(negedge clk);
        gx = 8; gy = 1; gz = 1; wx = 2; wy = 1; wz = 1;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        disp = 1'b1;
        @(negedge clk);
        disp = 1'b0;
        for (int n = 0; n < 200 && busy; n++) @(negedge clk);
        chk(gid == 0 && idx == 0, "R8", "dispatch during busy", longint'(gid), 0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            longint k;
            do_load(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            chk(cx == SW'(VEC[v][6]), "R3", "count x", longint'(cx), VEC[v][6]);
            chk(cy == SW'(VEC[v][7]), "R3", "count y", longint'(cy), VEC[v][7]);
            chk(cz == SW'(VEC[v][8]), "R3", "count z", longint'(cz), VEC[v][8]);
            chk(total == TW'(VEC[v][9]), "R4", "total", longint'(total), VEC[v][9]);
            chk(gid == 0 && completed == 0 && !complete, "R2", "state cleared by load",
                longint'(gid), 0);
            k = 0;
            for (int z = 0; z < VEC[v][8]; z++) begin
                for (int y = 0; y < VEC[v][7]; y++) begin
                    for (int x = 0; x < VEC[v][6]; x++) begin
                        chk(gid == TW'(k) && !complete, "R5", "flat index", longint'(gid), k);
                        chk(idx == SW'(x) && idy == SW'(y) && idz == SW'(z), "R6",
                            "coordinate zyx", longint'({idz, idy, idx}),
                            longint'({SW'(z), SW'(y), SW'(x)}));
                        k++;
                        pulse_disp();
                    end
                end
            end
            chk(complete == 1'b1, "R7", "complete after last", longint'(complete), 1);
            chk(idx == 0 && idy == 0 && idz == SW'(VEC[v][8]), "R7", "final z",
                longint'(idz), VEC[v][8]);
            chk(gid == TW'(VEC[v][9]), "R7", "final flat index", longint'(gid), VEC[v][9]);
            pulse_disp();
            chk(gid == TW'(VEC[v][9]) && idz == SW'(VEC[v][8]) && idx == 0 && complete,
                "R8", "dispatch after complete", longint'(gid), VEC[v][9]);
            for (int n = 0; n < VEC[v][9]; n++) begin
                pulse_done();
                if (n == VEC[v][9] - 2)
                    chk(all_done == 1'b0, "R10", "one retire missing", longint'(all_done), 0);
            end
            chk(completed == TW'(VEC[v][9]), "R9", "retire count", longint'(completed), VEC[v][9]);
            chk(all_done == 1'b1, "R10", "all retired", longint'(all_done), 1);
        end

        // R10 retires arriving before dispatch finishes
        do_load(4, 1, 1, 2, 1, 1);
        pulse_done();
        pulse_done();
        chk(completed == 2, "R9", "retires before dispatch", longint'(completed), 2);
        chk(all_done == 1'b0, "R10", "count met but not complete", longint'(all_done), 0);
        pulse_disp();
        pulse_disp();
        chk(all_done == 1'b1, "R10", "complete after early retires", longint'(all_done), 1);

        // R2 load in the middle of a walk
        do_load(9, 9, 1, 3, 3, 1);
        pulse_disp();
        pulse_disp();
        pulse_disp();
        pulse_done();
        chk(idx == 0 && idy == 1 && gid == 3, "R6", "mid-walk position", longint'(gid), 3);
        do_load(9, 9, 1, 3, 3, 1);
        chk(gid == 0 && idx == 0 && idy == 0 && completed == 0 && !complete, "R2",
            "reload clears", longint'(gid), 0);

        // R3 R4 near the divider range limit
        do_load(65535, 65535, 1000, 1, 256, 7);
        chk(cx == 65535, "R3", "wide count x", longint'(cx), 65535);
        chk(cy == 256, "R3", "ragged count y", longint'(cy), 256);
        chk(cz == 143, "R3", "ragged count z", longint'(cz), 143);
        chk(total == TW'(longint'(65535) * 256 * 143), "R4", "wide total", longint'(total),
            longint'(65535) * 256 * 143);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule